// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Control Decoder

This block is the control logic on the memory side of an asynchronous pseudo-static RAM. It watches six active-level control pins: chip select, write strobe, read strobe, two byte-lane enables and a register-access strobe. From them it picks one action:

- a word or single-byte access to a small internal array,
- a read or a program of one of three configuration registers,
- no operation,
- standby,
- deep power-down.

The 16-bit data path is split into a lower and an upper byte lane. Each lane has its own drive enable, so high impedance can be observed per lane. The outside bus is modelled as a separate input, output and two drive enables.

The pins are asynchronous, but the model is timed by a fast sampling clock `clk`:

- Read data and drive enables follow the pins combinationally.
- Array writes, register programs and power-state changes take effect at the next rising edge of `clk`.
- The burst clock pin `k_clk` plays no part in asynchronous operation and must be held low.

A three-state power machine tracks the device:

| State | Meaning |
|---|---|
| ST_STBY | deselected |
| ST_SEL | selected |
| ST_DPD | deep power-down |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| T_SELECT | ST_STBY | ST_SEL | `ce_n` low |
| T_DESELECT | ST_SEL | ST_STBY | `ce_n` high, refresh bit 4 = 1 |
| T_SLEEP | ST_STBY or ST_SEL | ST_DPD | `ce_n` high, refresh bit 4 = 0 |
| T_WAKE | ST_DPD | ST_SEL | `ce_n` low |

Top module: `psram_async_ctrl`

## Requirements
- R1: With `ce_n`=0, `we_n`=1, `oe_n`=0, `cre`=0 and both `lb_n`,`ub_n`=0 outside power-down, both lanes drive (`dq_oe_lo`=`dq_oe_hi`=1) in the same cycle, and `dq_out` equals the array word at index `addr[3:0]`.
- R2: In a read with only `lb_n`=0, only `dq_oe_lo` is 1 and `dq_out[7:0]` carries the lower byte. With only `ub_n`=0, only `dq_oe_hi` is 1 and `dq_out[15:8]` carries the upper byte.
- R3: With `ce_n`=0, `we_n`=0, `cre`=0, whatever `oe_n` is, each lane whose enable is 0 stores its `dq_in` byte at the next rising edge. The other lane keeps its old byte. Neither lane drives during a write.
- R4: A register read (`cre`=1, `ce_n`=0, `we_n`=1, `oe_n`=0) drives both lanes regardless of the byte enables. The register is chosen by `addr[19:18]`: 00 gives the refresh register, 10 gives the bus register, and 01 or 11 gives the identity register.
- R5: A register program (`cre`=1, `ce_n`=0, `we_n`=0) loads `addr[15:0]` into the refresh or bus register at the next edge. A program aimed at the identity register leaves it at `DID_VALUE`.
- R6: With `ce_n`=0 and both `we_n` and `oe_n` at 1, no lane drives and no stored state changes.
- R7: With `ce_n`=1 and not in power-down, no lane drives and no stored state changes.
- R8: At an edge where `ce_n`=1 and refresh bit 4 is 0, the device enters power-down. Every array byte is lost, and a lost byte reads back as the matching byte of `LOST_WORD` (16'hDEAD) until it is rewritten.
- R9: In power-down no lane drives and no access takes effect. At the first edge with `ce_n`=0 the device wakes and refresh bit 4 is set to 1.
- R10: After reset:
  - the refresh register is 16'h0010;
  - the bus register is `BCR_RST` (16'h9D1F, bit 15 = 1, asynchronous mode);
  - every array byte reads as lost;
  - `k_clk` must be held low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the model |
| rst_n | input | 1 | Active-low asynchronous reset |
| k_clk | input | 1 | Burst clock pin, required low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| lb_n | input | 1 | Lower byte-lane enable, active low |
| ub_n | input | 1 | Upper byte-lane enable, active low |
| cre | input | 1 | Register-access strobe, active high |
| addr | input | 22 | Address; also register select and register program data |
| dq_in | input | 16 | Data from the bus |
| dq_out | output | 16 | Data to the bus |
| dq_oe_lo | output | 1 | Drive enable of bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable of bits 15:8 |

## Verification
Read data and the lane drive enables are due in the same cycle the pins are applied. Array writes, register programs, power-down entry and wake are due one rising edge later. The bench applies each vector one nanosecond after a rising edge and compares the ports at the following falling edge. Its reference model is updated at the rising edge that ends the vector, so an effect is expected exactly from the next vector on. The power-down sequence deliberately places an access in the waking cycle, to confirm it is dropped and only the following cycle runs normally.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ARR_RD,
        OP_ARR_WR,
        OP_CFG_RD,
        OP_CFG_WR
    } op_e;

    typedef enum logic [1:0] {
        CFG_RCR,
        CFG_BCR,
        CFG_DID
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_STBY,
        ST_SEL,
        ST_DPD
    } pwr_st_e;

    localparam int DATA_W     = 16;
    localparam int LANE_W     = 8;
    localparam int LANES      = DATA_W / LANE_W;
    localparam int DPD_BIT    = 4;
    localparam int SEL_LO_BIT = 18;

endpackage

// File: rtl/psram_op_decode.sv
module psram_op_decode
    import psram_pkg::*;
(
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       cre,
    input  logic       lb_n,
    input  logic       ub_n,
    input  logic       in_dpd,
    input  logic [1:0] a_sel,
    output op_e        op,
    output logic       lane_lo,
    output logic       lane_hi,
    output cfg_sel_e   cfg_sel
);

    always_comb begin
        op      = OP_NONE;
        lane_lo = 1'b0;
        lane_hi = 1'b0;
        if (!in_dpd && !ce_n) begin
            if (!we_n)      op = cre ? OP_CFG_WR : OP_ARR_WR;
            else if (!oe_n) op = cre ? OP_CFG_RD : OP_ARR_RD;
        end
        unique case (op)
            OP_ARR_RD, OP_ARR_WR: begin
                lane_lo = !lb_n;
                lane_hi = !ub_n;
            end
            OP_CFG_RD: begin
                lane_lo = 1'b1;
                lane_hi = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (a_sel[0])      cfg_sel = CFG_DID;
        else if (a_sel[1]) cfg_sel = CFG_BCR;
        else               cfg_sel = CFG_RCR;
    end

endmodule

// File: rtl/psram_array.sv
module psram_array
    import psram_pkg::*;
#(
    parameter int          DEPTH     = 16,
    parameter logic [15:0] LOST_WORD = 16'hDEAD,
    localparam int         IDX_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lose,
    output logic [DATA_W-1:0] rdata
);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [DEPTH-1:0]  vld;

        always_ff @(posedge clk) begin
            if (wr_lane[ln]) mem[idx] <= wdata[ln*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           vld <= '0;
            else if (lose)        vld <= '0;
            else if (wr_lane[ln]) vld[idx] <= 1'b1;
        end

        assign rdata[ln*LANE_W +: LANE_W] =
            vld[idx] ? mem[idx] : LOST_WORD[ln*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
    import psram_pkg::*;
#(
    parameter logic [15:0] RCR_RST   = 16'h0010,
    parameter logic [15:0] BCR_RST   = 16'h9D1F,
    parameter logic [15:0] DID_VALUE = 16'h0E5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cfg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wake,
    output logic [DATA_W-1:0] rdata,
    output logic              rcr_b4
);

    logic [DATA_W-1:0] rcr_q;
    logic [DATA_W-1:0] bcr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcr_q <= RCR_RST;
            bcr_q <= BCR_RST;
        end else if (wake) begin
            rcr_q[DPD_BIT] <= 1'b1;
        end else if (wr_en) begin
            unique case (sel)
                CFG_RCR: rcr_q <= wdata;
                CFG_BCR: bcr_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            CFG_RCR: rdata = rcr_q;
            CFG_BCR: rdata = bcr_q;
            default: rdata = DID_VALUE;
        endcase
    end

    assign rcr_b4 = rcr_q[DPD_BIT];

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
    import psram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic rcr_b4,
    output logic in_dpd,
    output logic wake,
    output logic lose
);

    pwr_st_e st_q;
    pwr_st_e st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STBY;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_STBY: begin
                if (!ce_n)        st_nx = ST_SEL;   // T_SELECT
                else if (!rcr_b4) st_nx = ST_DPD;   // T_SLEEP
            end
            ST_SEL: begin
                if (ce_n) st_nx = rcr_b4 ? ST_STBY : ST_DPD; // T_DESELECT / T_SLEEP
            end
            ST_DPD: begin
                if (!ce_n) st_nx = ST_SEL;          // T_WAKE
            end
            default: st_nx = ST_STBY;
        endcase
    end

    always_comb begin
        in_dpd = (st_q == ST_DPD);
        wake   = (st_q == ST_DPD) && (st_nx == ST_SEL);
        lose   = (st_q != ST_DPD) && (st_nx == ST_DPD);
    end

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
    import psram_pkg::*;
#(
    parameter int          ADDR_W    = 22,
    parameter int          DEPTH     = 16,
    parameter logic [15:0] LOST_WORD = 16'hDEAD,
    parameter logic [15:0] BCR_RST   = 16'h9D1F,
    parameter logic [15:0] DID_VALUE = 16'h0E5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_clk,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic              cre,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic              dq_oe_lo,
    output logic              dq_oe_hi
);

    localparam int IDX_W = $clog2(DEPTH);

    op_e               op;
    cfg_sel_e          cfg_sel;
    logic              lane_lo;
    logic              lane_hi;
    logic              st_dpd;
    logic              wake;
    logic              lose;
    logic              rcr_b4;
    logic              rd_cyc;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] cfg_rdata;
    logic [LANES-1:0]  wr_lane;
    logic              unused_pins;

    psram_op_decode u_dec (
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .cre     (cre),
        .lb_n    (lb_n),
        .ub_n    (ub_n),
        .in_dpd  (st_dpd),
        .a_sel   (addr[SEL_LO_BIT +: 2]),
        .op      (op),
        .lane_lo (lane_lo),
        .lane_hi (lane_hi),
        .cfg_sel (cfg_sel)
    );

    psram_pwr_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .rcr_b4 (rcr_b4),
        .in_dpd (st_dpd),
        .wake   (wake),
        .lose   (lose)
    );

    assign wr_lane = (op == OP_ARR_WR) ? {lane_hi, lane_lo} : '0;

    psram_array #(
        .DEPTH     (DEPTH),
        .LOST_WORD (LOST_WORD)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (addr[IDX_W-1:0]),
        .wr_lane (wr_lane),
        .wdata   (dq_in),
        .lose    (lose),
        .rdata   (arr_rdata)
    );

    psram_cfg_regs #(
        .BCR_RST   (BCR_RST),
        .DID_VALUE (DID_VALUE)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (op == OP_CFG_WR),
        .sel    (cfg_sel),
        .wdata  (addr[DATA_W-1:0]),
        .wake   (wake),
        .rdata  (cfg_rdata),
        .rcr_b4 (rcr_b4)
    );

    assign rd_cyc   = (op == OP_ARR_RD) || (op == OP_CFG_RD);
    assign dq_oe_lo = rd_cyc && lane_lo;
    assign dq_oe_hi = rd_cyc && lane_hi;
    assign dq_out   = (op == OP_CFG_RD) ? cfg_rdata : arr_rdata;

    assign unused_pins = ^{k_clk, addr[ADDR_W-1:SEL_LO_BIT+2], addr[SEL_LO_BIT-1:DATA_W]};

endmodule

// File: rtl/psram_async_chk.sv
module psram_async_chk (
    input logic clk,
    input logic rst_n,
    input logic k_clk,
    input logic ce_n,
    input logic we_n,
    input logic oe_n,
    input logic lb_n,
    input logic ub_n,
    input logic cre,
    input logic oe_lo,
    input logic oe_hi,
    input logic in_dpd,
    input logic rcr_b4
);

    p_kclk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !k_clk);

    p_lane_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n && !cre && !in_dpd) |->
            (oe_lo == !lb_n) && (oe_hi == !ub_n));

    p_cfg_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n && cre && !in_dpd) |-> (oe_lo && oe_hi));

    p_write_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |-> (!oe_lo && !oe_hi));

    p_nop_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |-> (!oe_lo && !oe_hi));

    p_stby_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!oe_lo && !oe_hi));

    p_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_dpd && ce_n && !rcr_b4) |=> in_dpd);

    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dpd && !ce_n) |=> (!in_dpd && rcr_b4));

    p_dpd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_dpd |-> (!oe_lo && !oe_hi));

endmodule

bind psram_async_ctrl psram_async_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .k_clk  (k_clk),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .lb_n   (lb_n),
    .ub_n   (ub_n),
    .cre    (cre),
    .oe_lo  (dq_oe_lo),
    .oe_hi  (dq_oe_hi),
    .in_dpd (st_dpd),
    .rcr_b4 (rcr_b4)
);

// File: tb/test_psram_async_ctrl.sv
`timescale 1ns/1ps
module test_psram_async_ctrl;

    localparam int          DEPTH = 16;
    localparam logic [15:0] LOST  = 16'hDEAD;
    localparam logic [15:0] BCRR  = 16'h9D1F;
    localparam logic [15:0] DIDV  = 16'h0E5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        k_clk = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        lb_n = 1'b1, ub_n = 1'b1, cre = 1'b0;
    logic [21:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe_lo, dq_oe_hi;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0]  m_lo [DEPTH];
    logic [7:0]  m_hi [DEPTH];
    bit          v_lo [DEPTH];
    bit          v_hi [DEPTH];
    logic [15:0] m_rcr, m_bcr;
    bit          m_dpd;

    always #4 clk = ~clk;

    psram_async_ctrl #(
        .DEPTH     (DEPTH),
        .LOST_WORD (LOST),
        .BCR_RST   (BCRR),
        .DID_VALUE (DIDV)
    ) i_psram_async_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_clk    (k_clk),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .lb_n     (lb_n),
        .ub_n     (ub_n),
        .cre      (cre),
        .addr     (addr),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe_lo (dq_oe_lo),
        .dq_oe_hi (dq_oe_hi)
    );

    function automatic logic [15:0] m_cfg();
        if (addr[18])      return DIDV;
        else if (addr[19]) return m_bcr;
        else               return m_rcr;
    endfunction

    task automatic compare(input string tag);
        bit          e_lo = 1'b0;
        bit          e_hi = 1'b0;
        logic [15:0] e_d  = '0;
        bit          ok;
        int          i = int'(addr[3:0]);
        if (!m_dpd && !ce_n && we_n && !oe_n) begin
            if (cre) begin
                e_lo = 1'b1; e_hi = 1'b1; e_d = m_cfg();
            end else begin
                e_lo = !lb_n; e_hi = !ub_n;
                e_d  = {v_hi[i] ? m_hi[i] : LOST[15:8], v_lo[i] ? m_lo[i] : LOST[7:0]};
            end
        end
        n_vec++;
        ok = (dq_oe_lo === e_lo) && (dq_oe_hi === e_hi)
             && (!e_lo || dq_out[7:0] === e_d[7:0])
             && (!e_hi || dq_out[15:8] === e_d[15:8]);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: oe_lo/oe_hi/dq actual %b %b %h expected %b %b %h",
                     tag, dq_oe_lo, dq_oe_hi, dq_out, e_lo, e_hi, e_d);
        end
    endtask

    task automatic model_update();
        int i = int'(addr[3:0]);
        if (m_dpd) begin
            if (!ce_n) begin m_dpd = 1'b0; m_rcr[4] = 1'b1; end
        end else if (ce_n) begin
            if (!m_rcr[4]) begin
                m_dpd = 1'b1;
                for (int k = 0; k < DEPTH; k++) begin v_lo[k] = 1'b0; v_hi[k] = 1'b0; end
            end
        end else if (!we_n) begin
            if (cre) begin
                if (!addr[18]) begin
                    if (addr[19]) m_bcr = addr[15:0];
                    else          m_rcr = addr[15:0];
                end
            end else begin
                if (!lb_n) begin m_lo[i] = dq_in[7:0];  v_lo[i] = 1'b1; end
                if (!ub_n) begin m_hi[i] = dq_in[15:8]; v_hi[i] = 1'b1; end
            end
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        compare(tag);
        @(posedge clk);
        model_update();
        #1;
    endtask

    task automatic pins(input logic c, w, o, r, l, u, input logic [21:0] a, input logic [15:0] d);
        ce_n = c; we_n = w; oe_n = o; cre = r; lb_n = l; ub_n = u; addr = a; dq_in = d;
    endtask

    task automatic idle(input string tag);
        pins(1, 1, 1, 0, 1, 1, '0, '0); step(tag);
    endtask
    task automatic nop(input int a, input string tag);
        pins(0, 1, 1, 0, 0, 0, 22'(a), 16'hFFFF); step(tag);
    endtask
    task automatic rd(input int a, input logic l, u, input string tag);
        pins(0, 1, 0, 0, l, u, 22'(a), '0); step(tag);
    endtask
    task automatic wr(input int a, input logic [15:0] d, input logic l, u, o, input string tag);
        pins(0, 0, o, 0, l, u, 22'(a), d); step(tag);
    endtask
    task automatic cfg_rd(input logic [1:0] s, input string tag);
        pins(0, 1, 0, 1, 1, 1, {2'b00, s, 18'h0}, '0); step(tag);
    endtask
    task automatic cfg_wr(input logic [1:0] s, input logic [15:0] v, input string tag);
        pins(0, 0, 1, 1, 0, 0, {2'b00, s, 2'b00, v}, '0); step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        m_rcr = 16'h0010; m_bcr = BCRR; m_dpd = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin v_lo[k] = 1'b0; v_hi[k] = 1'b0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state of registers and array
        idle("R10");
        cfg_rd(2'b00, "R10");
        cfg_rd(2'b10, "R10");
        rd(3, 0, 0, "R10");

        // R1 / R3: word write then read, oe_n don't care
        wr(3, 16'h1234, 0, 0, 1, "R3");
        rd(3, 0, 0, "R1");
        wr(5, 16'hC0DE, 0, 0, 0, "R3");
        rd(5, 0, 0, "R1");

        // R3: byte writes leave the other lane
        wr(3, 16'hAB55, 0, 1, 1, "R3");
        rd(3, 0, 0, "R3");
        wr(3, 16'h77CC, 1, 0, 1, "R3");
        rd(3, 0, 0, "R3");
        wr(7, 16'h4411, 1, 0, 1, "R3");
        rd(7, 0, 0, "R3");

        // R2: single-lane reads
        rd(3, 0, 1, "R2");
        rd(3, 1, 0, "R2");
        rd(5, 1, 1, "R2");

        // R1: address pattern sweep
        for (int a = 0; a < DEPTH; a++) wr(a, 16'(a * 16'h1111) ^ 16'h5A3C, 0, 0, 1, "R1");
        for (int a = DEPTH - 1; a >= 0; a--) rd(a, 0, 0, "R1");

        // R4 / R5: configuration register select and program
        cfg_rd(2'b01, "R4");
        cfg_rd(2'b11, "R4");
        cfg_wr(2'b10, 16'h8123, "R5");
        cfg_rd(2'b10, "R5");
        cfg_wr(2'b01, 16'h1111, "R5");
        cfg_rd(2'b01, "R5");
        cfg_wr(2'b00, 16'h0017, "R5");
        cfg_rd(2'b00, "R5");

        // R6 / R7: no operation and standby keep state
        nop(2, "R6");
        rd(2, 0, 0, "R6");
        idle("R7");
        idle("R7");
        rd(2, 0, 0, "R7");
        cfg_rd(2'b00, "R7");

        // R8 / R9: power-down entry, dropped access on wake, data loss
        cfg_wr(2'b00, 16'h0000, "R8");
        idle("R8");
        idle("R8");
        wr(2, 16'hBEEF, 0, 0, 1, "R9");
        rd(2, 0, 0, "R8");
        rd(9, 0, 1, "R8");
        cfg_rd(2'b00, "R9");
        wr(2, 16'h2468, 0, 0, 1, "R8");
        rd(2, 0, 0, "R8");
        idle("R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule